// File: doc/BRIEF.md
# ADC Sample Interface Controller

This block sits between a register port on the system bus and an external sampling converter. It picks one of 32 event inputs as the hardware start source and watches that input for a chosen edge. It combines the detected edge with a software trigger and sends the converter a start pulse one cycle wide. The converter returns each 12-bit result with a one-cycle valid strobe. The block stores these results in a four-entry FIFO, which software drains through a data port. A status register reports the fill level and two sticky error flags.

Software sets a control register to disable the interface, enable it or flush it. A flush empties the FIFO and clears the error flags in two cycles. The interface then stays disabled until software enables it again. Software can also write words into the FIFO through the data port, which is useful for debug.

Top module: `adc_sample_ctrl`

## Requirements
- R1: After reset the control register reads 0 (disabled, source 0, rising edge), the status register reads 0x01 (empty only) and `conv_start` is low.
- R2: The control register at byte offset 0x10 holds the command in bits [1:0], the source select in bits [12:8] and the edge polarity in bit 13. A read returns these fields and 0 in every other bit.
- R3: The interface is enabled only while the command is 1. Commands 0 and 2 disable it. While disabled, no start pulse is issued for a hardware edge or a software trigger, and converter results are not stored.
- R4: Writing command 3 starts a flush. The command reads 3 for two cycles and then reads 0 (disabled). The FIFO ends empty and both sticky flags end cleared (status 0x01). The block then ignores triggers and converter results until command 1 is written.
- R5: Source codes 7, 8, 9 and 10 select no hardware event. Any other code N selects `evt_in[N]`.
- R6: Polarity bit 0 starts a conversion on a rising edge of the selected input. Polarity bit 1 starts on a falling edge. The `conv_start` pulse is high for exactly one cycle, in the second cycle after the cycle in which the input changes.
- R7: A write to byte offset 0x1C with bit 0 set raises `conv_start` in the next cycle. This works with any source select, including one whose input is idle. A write with bit 0 clear has no effect.
- R8: Changing the source select never produces a start pulse by itself, even when the old and new inputs differ in level.
- R9: The FIFO is first-in first-out and holds 4 entries. An entry is pushed when the interface is enabled and `conv_valid` is high, or when software writes bits [11:0] to offset 0x18. If both happen in the same cycle, only the converter word is stored. Reading 0x18 returns the oldest entry in bits [11:0] and pops it.
- R10: Status bit 0 is high when the FIFO is empty. Bit 1 is high when it holds exactly 3 entries. Bit 2 is high when it holds 4 entries.
- R11: A push into a full FIFO discards the word and sets status bit 4, which stays set until a flush. A push and a pop in the same cycle on a full FIFO both take place and do not set bit 4.
- R12: A pop from an empty FIFO returns 0, leaves the FIFO empty and sets status bit 3, which stays set until a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of 0x18 pops the FIFO |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| evt_in | input | 32 | Candidate hardware start events |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_valid | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter result word |

## Verification
The bench builds the block with its default parameters: 32 event inputs, 12-bit samples, a FIFO depth of 4 and a two-cycle flush. With a depth of only 4, a few random pushes reach the full, almost-full and overflow states, and a few random pops reach the underflow state. These states are mixed with flushes and re-enables. Because there are 32 inputs, the quiet source codes 7 to 10 fall inside the select range and can be checked against live inputs on either side of them.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;

  typedef enum logic [1:0] {
    CMD_DIS   = 2'd0,
    CMD_EN    = 2'd1,
    CMD_RSVD  = 2'd2,
    CMD_FLUSH = 2'd3
  } cmd_e;

  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_FIFO = 8'h18;
  localparam logic [7:0] OFS_TRIG = 8'h1C;

  localparam int QUIET_LO = 7;
  localparam int QUIET_HI = 10;

  // source codes that never route a hardware event
  function automatic logic src_is_quiet(input int code);
    return (code >= QUIET_LO) && (code <= QUIET_HI);
  endfunction

  // status word: {ovf, unf, full, almost_full, empty}
  function automatic logic [4:0] status_word(input int cnt, input int depth,
                                             input logic ovf, input logic unf);
    return {ovf, unf, cnt == depth, cnt == depth - 1, cnt == 0};
  endfunction

endpackage

// File: rtl/adc_start_gen.sv
module adc_start_gen
  import adc_if_pkg::*;
#(
  parameter int N_EVT = 32,
  parameter int SEL_W = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             fall,
  input  logic             en,
  input  logic             sw_trig,
  output logic             hw_edge,
  output logic             conv_start
);

  logic [SEL_W-1:0] sel_d;
  logic             sample_q, prev_q;
  logic [1:0]       hist_q;
  logic             raw;
  logic             sel_changed;

  assign sel_changed = sel != sel_d;
  assign raw = src_is_quiet(int'(sel)) ? 1'b0 : evt_in[sel];
  assign hw_edge = hist_q[1] &&
                   (fall ? (prev_q & ~sample_q) : (~prev_q & sample_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d      <= '0;
      sample_q   <= 1'b0;
      prev_q     <= 1'b0;
      hist_q     <= 2'b00;
      conv_start <= 1'b0;
    end else begin
      sel_d      <= sel;
      sample_q   <= raw;
      prev_q     <= sample_q;
      hist_q     <= sel_changed ? 2'b00 : {hist_q[0], 1'b1};
      conv_start <= en && (hw_edge || sw_trig);
    end
  end

  AST_NO_EDGE_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |=> !hw_edge); // R8

  AST_QUIET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (src_is_quiet(int'(sel)) && src_is_quiet(int'($past(sel))) &&
     $past(sel) == sel) |=> !hw_edge); // R5

endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 12,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push_req,
  input  logic [W-1:0]     push_data,
  input  logic             pop_req,
  output logic [W-1:0]     pop_data,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             unf
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             empty, full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = count == '0;
  assign full     = count == CNT_W'(DEPTH);
  assign do_pop   = !clr && pop_req && !empty;
  assign do_push  = !clr && push_req && (!full || do_pop);
  assign pop_data = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_req && !do_push) ovf <= 1'b1;
      if (pop_req && empty)     unf <= 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (full && push_req && !pop_req) |=> (count == CNT_W'(DEPTH)) && ovf); // R11

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && !clr) |=> unf); // R12

  AST_POP_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (pop_data == '0)); // R12

endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl
  import adc_if_pkg::*;
#(
  parameter int N_EVT     = 32,
  parameter int DATA_W    = 12,
  parameter int DEPTH     = 4,
  parameter int FLUSH_CYC = 2,
  parameter int SEL_W     = $clog2(N_EVT),
  parameter int CNT_W     = $clog2(DEPTH + 1),
  parameter int FCNT_W    = $clog2(FLUSH_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_EVT-1:0]  evt_in,
  output logic              conv_start,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data
);

  cmd_e              cmd_q;
  logic [SEL_W-1:0]  src_q;
  logic              fall_q;
  logic [FCNT_W-1:0] fcnt_q;

  logic ctrl_wr, trig_wr, fifo_wr, fifo_rd;
  logic en, flushing, flush_done, sw_trig, hw_edge;
  logic conv_take, push_req, pop_req;
  logic [DATA_W-1:0] push_data, pop_data;
  logic [CNT_W-1:0]  fcount;
  logic              ovf, unf;
  logic [4:0]        stat;

  assign ctrl_wr    = reg_wr && reg_addr == OFS_CTRL;
  assign trig_wr    = reg_wr && reg_addr == OFS_TRIG;
  assign fifo_wr    = reg_wr && reg_addr == OFS_FIFO;
  assign fifo_rd    = reg_rd && reg_addr == OFS_FIFO;
  assign en         = cmd_q == CMD_EN;
  assign flushing   = cmd_q == CMD_FLUSH;
  assign flush_done = flushing && fcnt_q == '0;
  assign sw_trig    = trig_wr && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_DIS;
      src_q  <= '0;
      fall_q <= 1'b0;
      fcnt_q <= '0;
    end else if (ctrl_wr) begin
      cmd_q  <= cmd_e'(reg_wdata[1:0]);
      src_q  <= reg_wdata[8 +: SEL_W];
      fall_q <= reg_wdata[13];
      fcnt_q <= FCNT_W'(FLUSH_CYC - 1);
    end else if (flush_done) begin
      cmd_q  <= CMD_DIS;
    end else if (flushing) begin
      fcnt_q <= fcnt_q - 1'b1;
    end
  end

  adc_start_gen #(.N_EVT(N_EVT), .SEL_W(SEL_W)) u_start (
    .clk, .rst_n, .evt_in, .sel(src_q), .fall(fall_q), .en,
    .sw_trig, .hw_edge, .conv_start
  );

  // converter result has priority over a debug write in the same cycle
  assign conv_take = en && conv_valid;
  assign push_req  = !flushing && (conv_take || fifo_wr);
  assign push_data = conv_take ? conv_data : reg_wdata[DATA_W-1:0];
  assign pop_req   = !flushing && fifo_rd;

  adc_sample_fifo #(.DEPTH(DEPTH), .W(DATA_W), .CNT_W(CNT_W)) u_fifo (
    .clk, .rst_n, .clr(flushing), .push_req, .push_data, .pop_req,
    .pop_data, .count(fcount), .ovf, .unf
  );

  assign stat = status_word(int'(fcount), DEPTH, ovf, unf);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[1:0]          = cmd_q;
        reg_rdata[8 +: SEL_W]   = src_q;
        reg_rdata[13]           = fall_q;
      end
      OFS_STAT: reg_rdata[4:0]  = stat;
      OFS_FIFO: reg_rdata[DATA_W-1:0] = pop_data;
      default:  reg_rdata = '0;
    endcase
  end

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(cmd_q) == CMD_EN)); // R3

  AST_FLUSH_ENDS_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_done && !ctrl_wr) |=> (cmd_q == CMD_DIS) && (fcount == '0) && !ovf && !unf); // R4

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stat[2:0]) <= 1); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flushing) |=> ovf); // R11

endmodule

// File: tb/adc_sample_ctrl_tb_top.sv
`timescale 1ns/100ps
module adc_sample_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_in = '0;
  logic        conv_start;
  logic        conv_valid = 1'b0;
  logic [11:0] conv_data = '0;

  int n_tests = 0, n_fail = 0, pulses = 0;
  logic [11:0] mq[$];
  logic mo = 1'b0, mu = 1'b0;

  always #2.5 clk = ~clk;

  adc_sample_ctrl dut_i (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .evt_in, .conv_start, .conv_valid, .conv_data
  );

  always @(posedge clk) if (rst_n && conv_start) pulses++;

  function automatic logic [31:0] exp_stat(int n, logic o, logic u);
    logic [31:0] s = 0;
    s[0] = (n == 0); s[1] = (n == 3); s[2] = (n == 4); s[3] = u; s[4] = o;
    return s;
  endfunction

  function automatic logic [31:0] ctrl_val(int cmd, int src, int fall);
    return (32'(fall) << 13) | (32'(src) << 8) | 32'(cmd);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic conv(input logic [11:0] v);
    @(negedge clk); conv_valid = 1; conv_data = v;
    @(posedge clk); #1 conv_valid = 0;
  endtask

  task automatic set_evt(input int i, input logic v);
    @(negedge clk); evt_in[i] = v;
  endtask

  task automatic model_push(input logic [11:0] v);
    if (mq.size() == 4) mo = 1; else mq.push_back(v);
  endtask

  task automatic chk_stat(input string req, input string what);
    logic [31:0] d;
    rd(8'h14, d);
    chk(req, what, d, exp_stat(mq.size(), mo, mu));
  endtask

  task automatic do_flush();
    wr(8'h10, ctrl_val(3, 9, 0));
    idle(3);
    mq.delete(); mo = 0; mu = 0;
  endtask

  initial begin
    logic [31:0] d;
    int p0;
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int p0;
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk("R1", "conv_start after reset", conv_start, 0);
    rd(8'h10, d); chk("R1", "ctrl after reset", d, 0);
    rd(8'h14, d); chk("R1", "status after reset", d, 32'h01);

    // R2 field readback with junk in other bits
    wr(8'h10, 32'hFFFF_DAFD);
    rd(8'h10, d); chk("R2", "ctrl readback", d, 32'h0000_1A01);

    // R7 software trigger
    wr(8'h10, ctrl_val(1, 9, 0)); idle(4);
    p0 = pulses; wr(8'h1C, 1);
    chk("R7", "start next cycle", conv_start, 1);
    idle(1); chk("R7", "start one cycle", conv_start, 0);
    idle(2); chk("R7", "one trigger pulse", pulses - p0, 1);
    p0 = pulses; wr(8'h1C, 32'hFFFF_FFFE); idle(3);
    chk("R7", "bit0 clear no pulse", pulses - p0, 0);
    wr(8'h10, ctrl_val(1, 3, 0)); idle(4);
    p0 = pulses; wr(8'h1C, 1); idle(3);
    chk("R7", "trigger with hw source", pulses - p0, 1);

    // R6 rising edge with exact timing
    p0 = pulses; set_evt(3, 1);
    @(posedge clk); #1 chk("R6", "no pulse first cycle", conv_start, 0);
    @(posedge clk); #1 chk("R6", "pulse second cycle", conv_start, 1);
    @(posedge clk); #1 chk("R6", "pulse width", conv_start, 0);
    set_evt(3, 0); idle(4);
    chk("R6", "falling ignored in rise mode", pulses - p0, 1);
    wr(8'h10, ctrl_val(1, 3, 1)); idle(4);
    p0 = pulses; set_evt(3, 1); idle(4);
    chk("R6", "rising ignored in fall mode", pulses - p0, 0);
    set_evt(3, 0); idle(4);
    chk("R6", "falling edge starts", pulses - p0, 1);

    // R5 quiet codes and routing
    for (int c = 7; c <= 10; c++) begin
      wr(8'h10, ctrl_val(1, c, 0)); idle(4);
      p0 = pulses;
      @(negedge clk) evt_in = '1; idle(4);
      @(negedge clk) evt_in = '0; idle(4);
      chk("R5", $sformatf("quiet code %0d", c), pulses - p0, 0);
    end
    wr(8'h10, ctrl_val(1, 20, 0)); idle(4);
    p0 = pulses; set_evt(21, 1); idle(4);
    chk("R5", "other input not routed", pulses - p0, 0);
    set_evt(20, 1); idle(4);
    chk("R5", "code 20 routes evt 20", pulses - p0, 1);
    @(negedge clk) evt_in = '0; idle(4);

    // R8 select change makes no false edge
    wr(8'h10, ctrl_val(1, 6, 0)); set_evt(5, 1); idle(4);
    p0 = pulses; wr(8'h10, ctrl_val(1, 5, 0)); idle(6);
    chk("R8", "no pulse on select change", pulses - p0, 0);
    set_evt(5, 0); idle(3); set_evt(5, 1); idle(4);
    chk("R8", "armed after select change", pulses - p0, 1);
    @(negedge clk) evt_in = '0; idle(4);

    // R3 disabled ignores everything
    for (int c = 0; c <= 2; c += 2) begin
      wr(8'h10, ctrl_val(c, 3, 0)); idle(4);
      p0 = pulses;
      wr(8'h1C, 1); set_evt(3, 1); idle(4); set_evt(3, 0);
      conv(12'h123); idle(3);
      chk("R3", $sformatf("no pulse cmd %0d", c), pulses - p0, 0);
      rd(8'h14, d); chk("R3", $sformatf("no store cmd %0d", c), d, 32'h01);
    end

    // R9 R10 R11 R12 directed FIFO
    wr(8'h10, ctrl_val(1, 9, 0));
    conv(12'hA01); conv(12'hA02);
    rd(8'h14, d); chk("R10", "two entries", d, 32'h00);
    conv(12'hA03);
    rd(8'h14, d); chk("R10", "almost full at 3", d, 32'h02);
    wr(8'h18, 32'hFFFF_FB04);
    rd(8'h14, d); chk("R10", "full at 4", d, 32'h04);
    conv(12'hA05);
    rd(8'h14, d); chk("R11", "overflow sticky set", d, 32'h14);
    rd(8'h18, d); chk("R9", "order 1", d, 32'hA01);
    conv(12'hA06);
    @(negedge clk); conv_valid = 1; conv_data = 12'hA07; reg_rd = 1; reg_addr = 8'h18;
    #1 d = reg_rdata; @(posedge clk); #1 conv_valid = 0; reg_rd = 0;
    chk("R11", "push+pop on full reads oldest", d, 32'hA02);
    rd(8'h14, d); chk("R11", "push+pop on full stays full", d, 32'h14);
    rd(8'h18, d); chk("R9", "order 3", d, 32'hA03);
    rd(8'h18, d); chk("R9", "debug word", d, 32'hB04);
    rd(8'h18, d); chk("R9", "order 5", d, 32'hA06);
    rd(8'h18, d); chk("R9", "order 6", d, 32'hA07);
    rd(8'h18, d); chk("R12", "pop empty returns 0", d, 0);
    rd(8'h14, d); chk("R12", "underflow sticky", d, 32'h19);
    @(negedge clk); conv_valid = 1; conv_data = 12'h0C1; reg_wr = 1;
    reg_addr = 8'h18; reg_wdata = 32'h0D2;
    @(posedge clk); #1 conv_valid = 0; reg_wr = 0;
    rd(8'h18, d); chk("R9", "converter wins", d, 32'h0C1);
    rd(8'h14, d); chk("R9", "single entry stored", d, 32'h19);

    // R4 flush timing and stays disabled
    wr(8'h10, ctrl_val(3, 9, 0));
    rd(8'h10, d); chk("R4", "cmd 3 cycle 1", d[1:0], 3);
    rd(8'h10, d); chk("R4", "cmd 3 cycle 2", d[1:0], 3);
    rd(8'h10, d); chk("R4", "cmd 0 after flush", d[1:0], 0);
    rd(8'h14, d); chk("R4", "status after flush", d, 32'h01);
    p0 = pulses; wr(8'h1C, 1); conv(12'h111); idle(3);
    chk("R4", "no pulse after flush", pulses - p0, 0);
    rd(8'h14, d); chk("R4", "no store after flush", d, 32'h01);
    wr(8'h10, ctrl_val(1, 9, 0)); conv(12'h222);
    rd(8'h18, d); chk("R4", "works after re-enable", d, 32'h222);

    // random mix
    mq.delete(); mo = 0; mu = 0;
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [11:0] v;
      if (i % 80 == 79) begin
        do_flush();
        chk_stat("R4", "random flush");
        wr(8'h10, ctrl_val(1, 9, 0));
      end
      op = int'($urandom_range(0, 3));
      v = 12'($urandom);
      case (op)
        0: begin conv(v); model_push(v); end
        1: begin wr(8'h18, {20'hFFFFF, v}); model_push(v); end
        2: begin
          logic [11:0] e;
          if (mq.size() == 0) begin e = 0; mu = 1; end
          else e = mq.pop_front();
          rd(8'h18, d); chk("R9", "random pop", d, 32'(e));
        end
        default: chk_stat("R10", "random status");
      endcase
    end
    chk_stat("R11", "final status");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule